// File: doc/BRIEF.md
# Microoperation Register Cell Array

This block holds an accumulator register of parameterised width. Each clock cycle it can either keep its contents or carry out one of three register transfers: a one-place left shift, a bitwise exclusive-OR with an operand word, or a binary addition of that operand. Three separate command lines choose the transfer. A well-formed cycle raises at most one of them. The block has no pipeline: the result is visible one clock after the command.

Each bit position is its own cell. A cell is a full adder plus a four-way selector in front of its flip-flop. The selector chooses among the cell's own value, the value of the bit below it, the XOR term and the sum term. Carries ripple from bit 0 upwards through the cells. A small decoder turns the command lines into the selector code and the load enable.

If more than one command line is high in the same cycle, that cycle is rejected. The register and the carry keep their values, and a flag reports the conflict on the next cycle.

Top module: `mop_reg_array`

## Requirements
- R1: After a clock edge with `rst` high, `a_out` is 0, `carry_out` is 0 and `conflict_err` is 0.
- R2: After a cycle with all three command lines low, `a_out` and `carry_out` keep their previous values.
- R3: After a cycle with only `op_shift` high, `a_out` equals the previous value shifted left by one place. Bit 0 becomes 0 and the old most significant bit is discarded.
- R4: After a cycle with only `op_xor` high, `a_out` equals the previous `a_out` XOR `b_in`.
- R5: After a cycle with only `op_add` high, `a_out` equals (previous `a_out` + `b_in`) modulo 2^W, with carry into bit 0 equal to 0.
- R6: After a cycle with only `op_add` high, `carry_out` holds the carry out of the top bit of that addition. After any other cycle, `carry_out` is unchanged.
- R7: After a cycle with two or more command lines high, `conflict_err` is 1 and `a_out` and `carry_out` are unchanged. After a cycle with at most one command line high, `conflict_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_shift | input | 1 | Command: shift the register left by one place |
| op_xor | input | 1 | Command: load register XOR operand |
| op_add | input | 1 | Command: load register plus operand |
| b_in | input | W | Operand word |
| a_out | output | W | Register contents |
| carry_out | output | 1 | Carry out of the top bit from the most recent addition |
| conflict_err | output | 1 | High for one cycle after a cycle with more than one command line high |

## Verification
Any wrong value in a cell's flip-flop appears at once on `a_out`. The register is fed back through every transfer, so the error also spreads into later results. A shift moves it up one place per cycle, and an addition can carry it into higher bits and into `carry_out`. Because the bench compares every output against a behavioural model on every clock, a fault in the selector decoding or the carry chain shows up on the first cycle whose operands exercise it. Sequences that run add after add with full-scale operands expose carry faults within one clock.

// File: rtl/mop_pkg.sv
package mop_pkg;

    // Selector code for each bit cell's input multiplexer
    typedef enum logic [1:0] {
        SEL_KEEP  = 2'b00,
        SEL_SHIFT = 2'b01,
        SEL_XOR   = 2'b10,
        SEL_SUM   = 2'b11
    } cell_sel_e;

    localparam int unsigned DEFAULT_WIDTH = 8;

endpackage

// File: rtl/mop_cmd_decode.sv
module mop_cmd_decode
    import mop_pkg::*;
(
    input  logic      op_shift,
    input  logic      op_xor,
    input  logic      op_add,
    output cell_sel_e sel,
    output logic      load,
    output logic      conflict
);

    logic [1:0] active_cnt;

    always_comb begin
        active_cnt = {1'b0, op_shift} + {1'b0, op_xor} + {1'b0, op_add};
        conflict   = (active_cnt > 2'd1);
        load       = (active_cnt == 2'd1);
        sel        = SEL_KEEP;
        if (load) begin
            unique case (1'b1)
                op_shift: sel = SEL_SHIFT;
                op_xor:   sel = SEL_XOR;
                op_add:   sel = SEL_SUM;
                default:  sel = SEL_KEEP;
            endcase
        end
    end

endmodule

// File: rtl/mop_bit_cell.sv
module mop_bit_cell
    import mop_pkg::*;
(
    input  logic      a_self,
    input  logic      a_below,
    input  logic      b_bit,
    input  logic      c_in,
    input  cell_sel_e sel,
    output logic      d_next,
    output logic      c_out
);

    logic half;

    always_comb begin
        half  = a_self ^ b_bit;
        c_out = ((a_self | b_bit) & c_in) | (a_self & b_bit);
        unique case (sel)
            SEL_KEEP:  d_next = a_self;
            SEL_SHIFT: d_next = a_below;
            SEL_XOR:   d_next = half;
            SEL_SUM:   d_next = half ^ c_in;
            default:   d_next = a_self;
        endcase
    end

endmodule

// File: rtl/mop_reg_array.sv
module mop_reg_array
    import mop_pkg::*;
#(
    parameter int unsigned W = DEFAULT_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_shift,
    input  logic         op_xor,
    input  logic         op_add,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         carry_out,
    output logic         conflict_err
);

    localparam int unsigned CHAIN = W + 1;

    typedef struct packed {
        logic [W-1:0] acc;
        logic         carry;
        logic         err;
    } state_t;

    state_t state_d, state_q;

    cell_sel_e      sel;
    logic           load;
    logic           conflict;
    logic [CHAIN-1:0] chain;
    logic [W-1:0]   cell_d;

    mop_cmd_decode u_decode (
        .op_shift (op_shift),
        .op_xor   (op_xor),
        .op_add   (op_add),
        .sel      (sel),
        .load     (load),
        .conflict (conflict)
    );

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        logic below;
        if (i == 0) begin : g_lsb
            assign below = 1'b0;
        end else begin : g_upper
            assign below = state_q.acc[i-1];
        end
        mop_bit_cell u_cell (
            .a_self  (state_q.acc[i]),
            .a_below (below),
            .b_bit   (b_in[i]),
            .c_in    (chain[i]),
            .sel     (sel),
            .d_next  (cell_d[i]),
            .c_out   (chain[i+1])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.err = conflict;
        if (load) begin
            state_d.acc = cell_d;
            if (sel == SEL_SUM) begin
                state_d.carry = chain[W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign a_out        = state_q.acc;
    assign carry_out    = state_q.carry;
    assign conflict_err = state_q.err;

endmodule

// File: rtl/mop_reg_array_checker.sv
module mop_reg_array_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         op_shift,
    input logic         op_xor,
    input logic         op_add,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic         carry_out,
    input logic         conflict_err
);

    logic none_on, only_shift, only_xor, only_add, many_on;

    always_comb begin
        none_on    = !op_shift && !op_xor && !op_add;
        only_shift =  op_shift && !op_xor && !op_add;
        only_xor   = !op_shift &&  op_xor && !op_add;
        only_add   = !op_shift && !op_xor &&  op_add;
        many_on    = !none_on && !only_shift && !only_xor && !only_add;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (a_out == '0) && !carry_out && !conflict_err);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        none_on |=> $stable(a_out) && $stable(carry_out));

    a_r3_shift_left: assert property (@(posedge clk) disable iff (rst)
        only_shift |=> a_out == ($past(a_out) << 1));

    a_r4_xor_load: assert property (@(posedge clk) disable iff (rst)
        only_xor |=> a_out == ($past(a_out) ^ $past(b_in)));

    a_r5_r6_add_load: assert property (@(posedge clk) disable iff (rst)
        only_add |=> {carry_out, a_out} ==
            ({1'b0, $past(a_out)} + {1'b0, $past(b_in)}));

    a_r6_carry_keep: assert property (@(posedge clk) disable iff (rst)
        !only_add |=> $stable(carry_out));

    a_r7_conflict_flag: assert property (@(posedge clk) disable iff (rst)
        many_on |=> conflict_err && $stable(a_out));

    a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
        !many_on |=> !conflict_err);

endmodule

bind mop_reg_array mop_reg_array_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .op_shift     (op_shift),
    .op_xor       (op_xor),
    .op_add       (op_add),
    .b_in         (b_in),
    .a_out        (a_out),
    .carry_out    (carry_out),
    .conflict_err (conflict_err)
);

// File: tb/mop_reg_array_bench.sv
module mop_reg_array_bench;

    localparam int W = 8;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         op_shift, op_xor, op_add;
    logic [W-1:0] b_in;
    logic [W-1:0] a_out;
    logic         carry_out;
    logic         conflict_err;

    int checks = 0;
    int errors = 0;

    // behavioural reference state
    int m_a   = 0;
    int m_c   = 0;
    int m_err = 0;

    always #5 clk = ~clk;

    mop_reg_array #(.W(W)) u_mop_reg_array (
        .clk          (clk),
        .rst          (rst),
        .op_shift     (op_shift),
        .op_xor       (op_xor),
        .op_add       (op_add),
        .b_in         (b_in),
        .a_out        (a_out),
        .carry_out    (carry_out),
        .conflict_err (conflict_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        check(req, "a_out", int'(a_out), m_a);
        check(req, "carry_out", int'(carry_out), m_c);
        check(req, "conflict_err", int'(conflict_err), m_err);
    endtask

    // one clock with the given commands, model advanced, outputs checked after the edge
    task automatic step(input bit sh, input bit xr, input bit ad, input int b);
        int n;
        string req;
        @(negedge clk);
        op_shift = sh;
        op_xor   = xr;
        op_add   = ad;
        b_in     = b[W-1:0];
        n = int'(sh) + int'(xr) + int'(ad);
        if (n > 1) begin
            m_err = 1;
            req = "R7";
        end else begin
            m_err = 0;
            if (sh) begin
                m_a = (m_a << 1) & MASK;
                req = "R3";
            end else if (xr) begin
                m_a = (m_a ^ b) & MASK;
                req = "R4";
            end else if (ad) begin
                m_c = ((m_a + (b & MASK)) >> W) & 1;
                m_a = (m_a + b) & MASK;
                req = "R5/R6";
            end else begin
                req = "R2";
            end
        end
        @(posedge clk);
        #2;
        compare_all(req);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        op_shift = 1'b0;
        op_xor = 1'b0;
        op_add = 1'b0;
        b_in = '0;
        repeat (3) @(posedge clk);
        #2;
        m_a = 0; m_c = 0; m_err = 0;
        compare_all("R1");
        @(negedge clk);
        rst = 1'b0;

        // R4: load a pattern through XOR from zero
        step(0, 1, 0, 'hA5);
        // R2: idle keeps value
        step(0, 0, 0, 'hFF);
        step(0, 0, 0, 'h3C);
        // R3: shift drops the MSB and brings in 0
        step(1, 0, 0, 'hFF);
        step(1, 0, 0, 'h00);
        // R5/R6: carry produced on overflow
        step(0, 1, 0, 'h00);
        step(0, 1, 0, 'hFF ^ int'(a_out));
        step(0, 0, 1, 'h01);
        // R6: carry kept through non-add cycles
        step(0, 0, 0, 'h00);
        step(1, 0, 0, 'h00);
        step(0, 1, 0, 'h11);
        // R5: add with no overflow clears carry
        step(0, 0, 1, 'h02);
        step(0, 0, 1, 'hFF);
        step(0, 0, 1, 'hFF);
        // R7: every conflicting combination holds state and flags
        step(1, 1, 0, 'h55);
        step(1, 0, 1, 'h55);
        step(0, 1, 1, 'h55);
        step(1, 1, 1, 'h55);
        // R7: flag drops after a legal cycle
        step(0, 0, 0, 'h00);
        // R3: shift everything out
        for (int k = 0; k < W + 1; k++) step(1, 0, 0, 'h00);

        // mixed pattern sweep
        for (int k = 0; k < 400; k++) begin
            int sel;
            sel = int'($urandom_range(0, 7));
            step(sel[0], sel[1], sel[2], int'($urandom_range(0, MASK)));
        end

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        op_add = 1'b1;
        op_shift = 1'b1;
        @(posedge clk);
        #2;
        m_a = 0; m_c = 0; m_err = 0;
        compare_all("R1");
        @(negedge clk);
        rst = 1'b0;
        op_add = 1'b0;
        op_shift = 1'b0;
        step(0, 0, 1, 'h80);
        step(0, 0, 1, 'h80);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule